// File: doc/BRIEF.md
# Global Write-Enable Phase Generator

This block supplies the timing for a single-cycle processor whose memories only return data on a clock edge. Everything runs on one fast clock. Each processor step is four fast cycles long, numbered by a 2-bit phase counter. Within a step, the block raises strobes that say when the datapath may store to data memory, fetch an instruction and load data. It also raises a global write enable (`gwe`) that every architectural register ANDs with its local write enable. Registers therefore commit once per step without any logic on the clock.

Two modes select how steps start. In free-running mode, steps follow each other back to back. In single-step mode, the counter parks in phase 0 with every strobe low. A rising edge on `step_req` launches exactly one step, which begins in that same cycle. Once a step has left phase 0, it always runs to its end, whatever the mode input does.

Top module: `gwe_phase_gen`

## Requirements
- R1: In free-running mode (`single_step`=0), `phase` advances by one every fast cycle through 0,1,2,3 and wraps from 3 to 0.
- R2: `store_stb` is high only in phase 0 of a step that is actually executing, i.e. at the step boundary.
- R3: `fetch_stb` is high exactly when `phase` is 1, one fast cycle after the step boundary.
- R4: `load_stb` is high exactly when `phase` is 3, three fast cycles after the step boundary.
- R5: `gwe` is high exactly when `phase` is 3, so it lasts one fast cycle per step and never overlaps `store_stb` or `fetch_stb`.
- R6: While the synchronous, active-high `rst` is sampled high, all four strobes are low; on the following cycle `phase` is 0.
- R7: In single-step mode with no launch, a counter in phase 0 stays in phase 0 and all strobes stay low.
- R8: In single-step mode, a 0-to-1 change of `step_req` (compared with its value one cycle earlier) seen while `phase` is 0 starts one step: `store_stb` is high in that cycle and phases 1, 2, 3 follow, after which the counter waits in phase 0 again.
- R9: A `step_req` held high launches only one step. A rising edge that arrives while `phase` is 1, 2 or 3 is dropped and not queued.
- R10: A step that has left phase 0 always completes. Switching to single-step mode mid-step lets the counter reach phase 3 and then wait in phase 0.
- R11: The `step_req` history is cleared to 0 by reset, so a request held high through reset launches a step in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| single_step | input | 1 | 1 = single-step mode, 0 = free-running |
| step_req | input | 1 | Step request, acted on at its rising edge |
| phase | output | 2 | Current phase within the step (0..3) |
| gwe | output | 1 | Global write enable for register commit |
| store_stb | output | 1 | Data-store phase strobe |
| fetch_stb | output | 1 | Instruction-fetch phase strobe |
| load_stb | output | 1 | Data-load phase strobe |

## Verification
The hardest situations to reach from the ports are the ones where a request edge or a mode change lands in the middle of a step. Examples are a second rising edge in phase 2, or a switch to single-step mode in phase 1. Random stimulus seldom lines these up by itself. So directed sequences first launch a step and then, one cycle at a time, toggle `step_req` low and high or flip `single_step` while the counter is still in phases 1 to 3. Random traffic with frequent request toggles, mode flips and occasional resets then runs against a cycle model in the bench.

// File: rtl/gwe_phase_gen.sv
module gwe_phase_gen #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          single_step,
  input  logic          step_req,
  output logic [PW-1:0] phase,
  output logic          gwe,
  output logic          store_stb,
  output logic          fetch_stb,
  output logic          load_stb
);
  localparam logic [PW-1:0] PH_STORE = PW'(0);
  localparam logic [PW-1:0] PH_FETCH = PW'(1);
  localparam logic [PW-1:0] PH_LAST  = PW'((1 << PW) - 1);

  logic          req_q;
  logic          launch;
  logic          live;
  logic [PW-1:0] ph_q;

  assign launch = step_req & ~req_q;
  assign live   = ~rst & ((ph_q != PH_STORE) | ~single_step | launch);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_STORE;
      req_q <= 1'b0;
    end else begin
      req_q <= step_req;
      if (live) ph_q <= ph_q + PW'(1);
    end
  end

  assign phase     = ph_q;
  assign store_stb = live & (ph_q == PH_STORE);
  assign fetch_stb = ~rst & (ph_q == PH_FETCH);
  assign load_stb  = ~rst & (ph_q == PH_LAST);
  assign gwe       = ~rst & (ph_q == PH_LAST);
endmodule

module gwe_phase_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       single_step,
  input logic [1:0] phase,
  input logic       gwe,
  input logic       store_stb,
  input logic       fetch_stb,
  input logic       load_stb
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3) |=> (phase == 2'd0));
  assert_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_stb, fetch_stb, gwe}));
  assert_fetch_after_store_R3: assert property (@(posedge clk) disable iff (rst)
    store_stb |=> fetch_stb);
  assert_load_gwe_R4: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> gwe);
  assert_gwe_single_R5: assert property (@(posedge clk) disable iff (rst)
    gwe |=> !gwe);
  assert_reset_quiet_R6: assert property (@(posedge clk)
    rst |-> !(gwe || store_stb || fetch_stb || load_stb));
  assert_park_R7: assert property (@(posedge clk) disable iff (rst)
    (single_step && phase == 2'd0 && !store_stb) |=> (phase == 2'd0));
endmodule

bind gwe_phase_gen gwe_phase_gen_chk u_chk (
  .clk(clk), .rst(rst), .single_step(single_step), .phase(phase),
  .gwe(gwe), .store_stb(store_stb), .fetch_stb(fetch_stb), .load_stb(load_stb)
);

// File: tb/gwe_phase_gen_bench.sv
module gwe_phase_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ss = 1'b0;
  logic req = 1'b0;
  logic [1:0] phase;
  logic gwe, store_stb, fetch_stb, load_stb;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] m_ph = 2'd0;
  logic m_prev = 1'b0;

  always #4 clk = ~clk;

  gwe_phase_gen u_gwe_phase_gen (
    .clk(clk), .rst(rst), .single_step(ss), .step_req(req),
    .phase(phase), .gwe(gwe), .store_stb(store_stb),
    .fetch_stb(fetch_stb), .load_stb(load_stb)
  );

  function automatic logic exp_live(logic r, logic s, logic q, logic [1:0] p, logic pv);
    return !r && (p != 2'd0 || !s || (q && !pv));
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(logic r, logic s, logic q, string tag);
    logic lv;
    @(posedge clk);
    #1;
    rst = r; ss = s; req = q;
    lv = exp_live(r, s, q, m_ph, m_prev);
    #2;
    chk({tag, " phase"}, {2'b00, phase}, {2'b00, (r ? phase : m_ph)});
    chk("R2 store_stb", {3'b000, store_stb}, {3'b000, lv && m_ph == 2'd0});
    chk("R3 fetch_stb", {3'b000, fetch_stb}, {3'b000, !r && m_ph == 2'd1});
    chk("R4 load_stb", {3'b000, load_stb}, {3'b000, !r && m_ph == 2'd3});
    chk("R5 gwe", {3'b000, gwe}, {3'b000, !r && m_ph == 2'd3});
    m_prev = r ? 1'b0 : q;
    m_ph = r ? 2'd0 : (lv ? m_ph + 2'd1 : m_ph);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9157));
    // R6: reset state
    tick(1, 0, 0, "R6");
    tick(1, 0, 0, "R6");
    @(negedge clk);
    chk("R6 phase after reset", {2'b00, phase}, 4'd0);
    // R1: free-running sequence
    for (int i = 0; i < 10; i++) tick(0, 0, 0, "R1");
    // R10: switch to single-step mid-step
    while (m_ph != 2'd1) tick(0, 0, 0, "R1");
    tick(0, 1, 0, "R10");
    for (int i = 0; i < 5; i++) tick(0, 1, 0, "R10");
    // R7: parked
    for (int i = 0; i < 4; i++) tick(0, 1, 0, "R7");
    // R8 and R9: launch, hold high
    for (int i = 0; i < 8; i++) tick(0, 1, 1, "R8");
    // R9: edge inside step ignored
    tick(0, 1, 0, "R9");
    tick(0, 1, 1, "R8");
    tick(0, 1, 0, "R9");
    tick(0, 1, 1, "R9");
    for (int i = 0; i < 4; i++) tick(0, 1, 1, "R9");
    // R11: request high through reset
    tick(1, 1, 1, "R6");
    tick(1, 1, 1, "R6");
    for (int i = 0; i < 4; i++) tick(0, 1, 1, "R11");
    tick(0, 1, 0, "R11");
    tick(0, 1, 1, "R11");
    for (int i = 0; i < 4; i++) tick(0, 1, 0, "R8");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic r, s, q;
      r = ($urandom % 64) == 0;
      s = ($urandom % 4) != 0;
      q = ($urandom % 3) == 0;
      tick(r, s, q, s ? "R8" : "R1");
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule